// File: doc/BRIEF.md
# Interlocked Read Handshake over Shared Address/Data Lines

This block holds the two bus-side controllers of a read transfer: a requester that takes a read command and returns a data word, and a memory responder that holds a small word array. They talk over one set of shared lines that carries the address first and the data word second. Three control lines run between them: a read request, a data-valid flag and an acknowledge. No shared timing governs the transfer. Each side acts only when it sees the other side's control line change, so every phase is interlocked and a transfer takes as long as the slower side needs.

Each side passes the control lines it receives through a synchronizer chain before its state machine uses them. The shared lines are modelled as two gated drivers merged into one resolved value, and a clash flag shows any cycle where both drivers are enabled. A local command port starts a read. A one-cycle completion pulse returns the captured word once the final acknowledge has been seen low.

Top module: `rdhs_link`

## Requirements
- R1: Out of reset, all three control lines are low, the resolved lines read zero, `cmd_ready` is 1 and `done` is 0.
- R2: A command accepted while `cmd_ready` is 1 raises the read request with the command address on the low `AW` bits of the lines, and `cmd_ready` drops in the next cycle.
- R3: The responder raises acknowledge only after it has seen the request, and the requester drops the request (and releases the lines) only after it has seen that acknowledge.
- R4: After its acknowledge has fallen, the responder drives the word and raises the data-valid flag together. The word at address a is (a*37 + 11) mod 2^DW with the default parameters.
- R5: The two drivers of the lines are never enabled in the same cycle, so `bus_clash` stays 0.
- R6: The requester acknowledges the data. The responder then drops the data-valid flag and releases the lines, and after that the requester drops acknowledge. Written as {request, acknowledge, data-valid}, the control lines step through 100, 110, 010, 000, 001, 011, 010, 000 on every read.
- R7: `done` pulses for exactly one cycle after the final acknowledge is low, with `done_data` equal to the word read. `cmd_ready` is 1 in the next cycle.
- R8: A command presented while a read is in progress is ignored. The current read completes with its own address and data.
- R9: Reads issued back to back, one at each address of the array, each return the correct word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock of both controllers |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Start a read when the requester is idle |
| cmd_addr | input | AW | Word address of the read |
| cmd_ready | output | 1 | Requester idle and accepting a command |
| done | output | 1 | One-cycle completion pulse |
| done_data | output | DW | Word returned by the last read |
| line_req | output | 1 | Read request control line |
| line_ack | output | 1 | Acknowledge control line (both sides drive it) |
| line_rdy | output | 1 | Data-valid control line |
| bus_lines | output | max(AW,DW) | Resolved shared address/data lines |
| bus_clash | output | 1 | Both line drivers enabled in the same cycle |

## Verification
The embedded properties assume that only the two controllers drive the control lines and the shared lines. They also assume that reset is held long enough to clear the synchronizer chains, so that no stale sample from before reset can move a state machine. The local command port is the only free input. The bench changes it on falling edges only, drives one accepted command at a time, and adds an out-of-turn command only while a read is in progress, which checks that such a command cannot disturb the interlock.

// File: rtl/rdhs_pkg.sv
package rdhs_pkg;

   typedef enum logic [2:0] {
      M_IDLE,
      M_REQ,
      M_ACK_LO,
      M_WAIT_RDY,
      M_ACK_HI,
      M_REL,
      M_DONE
   } mst_state_t;

   typedef enum logic [2:0] {
      S_IDLE,
      S_ACK,
      S_GAP,
      S_DATA,
      S_REL
   } slv_state_t;

endpackage

// File: rtl/rdhs_sync.sv
module rdhs_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_depth
      $error("rdhs_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("rdhs_sync: W must be at least 1");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i] <= '0;
         else        chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/rdhs_master.sv
module rdhs_master
   import rdhs_pkg::*;
#(
   parameter int AW          = 4,
   parameter int DW          = 8,
   parameter int BW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [AW-1:0] cmd_addr,
   output logic          cmd_ready,
   output logic          done,
   output logic [DW-1:0] done_data,
   output logic          req_o,
   output logic          ack_o,
   input  logic          ack_i,
   input  logic          rdy_i,
   output logic          drv_en,
   output logic [BW-1:0] drv_val,
   input  logic [BW-1:0] lines_i
);

   mst_state_t    st;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;
   logic          ack_s, rdy_s;

   rdhs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ack_i, rdy_i}),
      .q     ({ack_s, rdy_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= M_IDLE;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         case (st)
            M_IDLE: if (cmd_valid) begin
               addr_q <= cmd_addr;
               st     <= M_REQ;
            end
            M_REQ:      if (ack_s)  st <= M_ACK_LO;
            M_ACK_LO:   if (!ack_s) st <= M_WAIT_RDY;
            M_WAIT_RDY: if (rdy_s) begin
               data_q <= lines_i[DW-1:0];
               st     <= M_ACK_HI;
            end
            M_ACK_HI:   if (!rdy_s) st <= M_REL;
            M_REL:      if (!ack_s) st <= M_DONE;
            M_DONE:     st <= M_IDLE;
            default:    st <= M_IDLE;
         endcase
      end
   end

   assign cmd_ready = (st == M_IDLE);
   assign done      = (st == M_DONE);
   assign done_data = data_q;
   assign req_o     = (st == M_REQ);
   assign ack_o     = (st == M_ACK_HI);
   assign drv_en    = (st == M_REQ);
   assign drv_val   = BW'(addr_q);

   // R3: the request only falls after the acknowledge has been seen
   a_r3_req_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_o) |-> $past(ack_s));
   // R7: completion is a single-cycle pulse
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7: completion only once the acknowledge line is low
   a_r7_done_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !ack_i);

endmodule

// File: rtl/rdhs_slave.sv
module rdhs_slave
   import rdhs_pkg::*;
#(
   parameter int AW          = 4,
   parameter int DW          = 8,
   parameter int BW          = 8,
   parameter int SYNC_STAGES = 2,
   parameter int MUL         = 37,
   parameter int OFS         = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_i,
   input  logic          ack_i,
   output logic          ack_o,
   output logic          rdy_o,
   output logic          drv_en,
   output logic [BW-1:0] drv_val,
   input  logic [BW-1:0] lines_i
);

   localparam int DEPTH = 1 << AW;

   slv_state_t    st;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] word_q;
   logic [DW-1:0] mem [DEPTH];
   logic          req_s, ack_s;

   rdhs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({req_i, ack_i}),
      .q     ({req_s, ack_s})
   );

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) mem[i] <= DW'(i * MUL + OFS);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         addr_q <= '0;
         word_q <= '0;
      end else begin
         case (st)
            S_IDLE: if (req_s) begin
               addr_q <= lines_i[AW-1:0];
               st     <= S_ACK;
            end
            S_ACK:  if (!req_s) st <= S_GAP;
            S_GAP:  if (!ack_s) begin
               word_q <= mem[addr_q];
               st     <= S_DATA;
            end
            S_DATA: if (ack_s)  st <= S_REL;
            S_REL:  if (!ack_s) st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   assign ack_o   = (st == S_ACK);
   assign rdy_o   = (st == S_DATA);
   assign drv_en  = (st == S_DATA);
   assign drv_val = BW'(word_q);

   // R4: data-valid rises only while the acknowledge line is low
   a_r4_rdy_after_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy_o) |-> !ack_i);
   // R6: data-valid falls only after the requester's acknowledge was seen
   a_r6_rdy_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rdy_o) |-> $past(ack_s));
   // R3: acknowledge rises only after a request was seen
   a_r3_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_o) |-> $past(req_s));

endmodule

// File: rtl/rdhs_link.sv
module rdhs_link #(
   parameter int AW          = 4,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2,
   parameter int MUL         = 37,
   parameter int OFS         = 11,
   localparam int BW         = (AW > DW) ? AW : DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [AW-1:0] cmd_addr,
   output logic          cmd_ready,
   output logic          done,
   output logic [DW-1:0] done_data,
   output logic          line_req,
   output logic          line_ack,
   output logic          line_rdy,
   output logic [BW-1:0] bus_lines,
   output logic          bus_clash
);

   if (AW < 1 || AW > 10) begin : g_bad_aw
      $error("rdhs_link: AW must be within 1..10");
   end
   if (DW < 1) begin : g_bad_dw
      $error("rdhs_link: DW must be at least 1");
   end

   logic          m_ack, s_ack;
   logic          m_en, s_en;
   logic [BW-1:0] m_val, s_val;

   rdhs_master #(.AW(AW), .DW(DW), .BW(BW), .SYNC_STAGES(SYNC_STAGES)) u_mst (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_addr  (cmd_addr),
      .cmd_ready (cmd_ready),
      .done      (done),
      .done_data (done_data),
      .req_o     (line_req),
      .ack_o     (m_ack),
      .ack_i     (line_ack),
      .rdy_i     (line_rdy),
      .drv_en    (m_en),
      .drv_val   (m_val),
      .lines_i   (bus_lines)
   );

   rdhs_slave #(.AW(AW), .DW(DW), .BW(BW), .SYNC_STAGES(SYNC_STAGES),
                .MUL(MUL), .OFS(OFS)) u_slv (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (line_req),
      .ack_i   (line_ack),
      .ack_o   (s_ack),
      .rdy_o   (line_rdy),
      .drv_en  (s_en),
      .drv_val (s_val),
      .lines_i (bus_lines)
   );

   assign line_ack  = m_ack | s_ack;
   assign bus_lines = (m_en ? m_val : '0) | (s_en ? s_val : '0);
   assign bus_clash = m_en & s_en;

   // R5: the two line drivers never overlap
   a_r5_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
      !(m_en && s_en));
   // R3 / R6: acknowledge only rises in answer to a request or to data-valid
   a_r6_ack_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_ack) |-> (line_req || line_rdy));

endmodule

// File: tb/rdhs_link_tb.sv
`timescale 1ns/1ps
module rdhs_link_tb;

   localparam int AW = 4;
   localparam int DW = 8;
   localparam int BW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [AW-1:0] cmd_addr = '0;
   logic          cmd_ready, done, line_req, line_ack, line_rdy, bus_clash;
   logic [DW-1:0] done_data;
   logic [BW-1:0] bus_lines;

   int n_checks = 0;
   int n_fail   = 0;
   logic [AW-1:0] exp_addr = '0;
   logic          finished = 1'b0;

   always #4 clk = ~clk;

   rdhs_link #(.AW(AW), .DW(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
      .cmd_ready(cmd_ready), .done(done), .done_data(done_data),
      .line_req(line_req), .line_ack(line_ack), .line_rdy(line_rdy),
      .bus_lines(bus_lines), .bus_clash(bus_clash)
   );

   function automatic logic [DW-1:0] word_at(input int a);
      return DW'((a * 37 + 11) % 256);
   endfunction

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Control-line order monitor, {req, ack, rdy}
   logic [2:0] seq [8] = '{3'b100, 3'b110, 3'b010, 3'b000,
                           3'b001, 3'b011, 3'b010, 3'b000};
   int         k = 0;
   logic [2:0] prev = 3'b000;

   always @(negedge clk) begin
      if (rst_n) begin
         logic [2:0] cur;
         cur = {line_req, line_ack, line_rdy};
         if (cur != prev) begin
            check(cur == seq[k], "R6 control order", int'(cur), int'(seq[k]));
            k = (k + 1) % 8;
            prev = cur;
         end
         check(bus_clash == 1'b0, "R5 no clash", int'(bus_clash), 0);
         if (line_req)
            check(bus_lines[AW-1:0] == exp_addr, "R2 address on lines",
                  int'(bus_lines[AW-1:0]), int'(exp_addr));
         if (line_rdy)
            check(bus_lines[DW-1:0] == word_at(int'(exp_addr)), "R4 data on lines",
                  int'(bus_lines[DW-1:0]), int'(word_at(int'(exp_addr))));
      end
   end

   task automatic do_read(input int a, input logic intrude);
      int guard;
      guard = 0;
      while (!cmd_ready && guard < 1000) begin
         @(negedge clk);
         guard++;
      end
      cmd_valid = 1'b1;
      cmd_addr  = AW'(a);
      exp_addr  = AW'(a);
      @(negedge clk);
      cmd_valid = 1'b0;
      check(cmd_ready == 1'b0, "R2 command accepted", int'(cmd_ready), 0);
      if (intrude) begin
         repeat (3) @(negedge clk);
         cmd_valid = 1'b1;
         cmd_addr  = AW'(a ^ 5);
         @(negedge clk);
         cmd_valid = 1'b0;
         check(cmd_ready == 1'b0, "R8 still busy", int'(cmd_ready), 0);
      end
      guard = 0;
      while (!done && guard < 1000) begin
         @(negedge clk);
         guard++;
      end
      check(done == 1'b1, "R7 done seen", int'(done), 1);
      check(line_ack == 1'b0, "R7 ack low at done", int'(line_ack), 0);
      check(done_data == word_at(a), intrude ? "R8 data of first command" : "R9 read data",
            int'(done_data), int'(word_at(a)));
      @(negedge clk);
      check(done == 1'b0, "R7 done single cycle", int'(done), 0);
      check(cmd_ready == 1'b1, "R7 ready again", int'(cmd_ready), 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(cmd_ready == 1'b1, "R1 cmd_ready", int'(cmd_ready), 1);
      check(done == 1'b0, "R1 done", int'(done), 0);
      check({line_req, line_ack, line_rdy} == 3'b000, "R1 control lines",
            int'({line_req, line_ack, line_rdy}), 0);
      check(bus_lines == '0, "R1 lines released", int'(bus_lines), 0);
      // R9 back-to-back sweep of every address (also R2, R3, R4, R6)
      for (int a = 0; a < (1 << AW); a++) do_read(a, 1'b0);
      // R8 intruding commands while busy
      do_read(9, 1'b1);
      do_read(0, 1'b1);
      do_read(15, 1'b1);
      // R3 handshake ended cleanly in the idle pattern
      check(k == 0, "R3 sequence complete", k, 0);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule